// File: doc/BRIEF.md
# Two-CPU Interrupt Distributor

The block gathers three kinds of interrupt source and presents, to each of two CPUs, the most urgent source that is currently eligible for it. Software-raised interrupts are created by a configuration write that names the source and picks one or both CPUs. Private per-CPU sources come in on a separate line per CPU and keep a separate copy of their state for each CPU. Shared sources arrive as level lines from peripherals and may be aimed at either CPU or at both.

Software programs enable, priority, target set and a per-CPU priority mask through a single-cycle write port. Each CPU takes an interrupt with a one-cycle acknowledge pulse and reads the granted number on the next cycle. It releases the interrupt with an end-of-interrupt pulse that carries the number. A shared source taken by one CPU is held back from the other until the owner releases it.

Top module: `irq_dist2`

## Requirements
- R1: A synchronous reset clears all pending and active state, every enable, priority (to 0) and target set, and loads every CPU mask with all ones. After reset `irq_o` is low and `ack_id_o` holds the spurious number (all ones).
- R2: A write with `cfg_we` high applies `cfg_op` on that clock edge. Code 0 writes enable from `cfg_data[0]`. Code 1 writes priority from the low `PRIO_W` bits. Code 2 writes a shared source's targets, with `cfg_data[c]` selecting CPU c. Code 3 raises a software source. Code 4 writes the mask of CPU `cfg_cpu`. Enable and priority writes to private and software sources go to the copy of CPU `cfg_cpu`.
- R3: Software sources take IDs 0 to N_SGI-1, private sources the next N_PPI, shared sources the rest. Among the candidates for a CPU, the smallest priority value wins, and a tie goes to the lower ID.
- R4: An acknowledge pulse on CPU c places the granted ID on `ack_id_o[c]` on the following cycle and moves that source from pending to active. With nothing eligible, the spurious ID is returned and no state changes.
- R5: When both CPUs acknowledge the same shared source in one cycle, CPU 0 gets it and CPU 1 gets the spurious ID. While the source is active it is offered to no CPU. An end-of-interrupt for it from the non-owning CPU is ignored.
- R6: A raise write (code 3) sets the software source `cfg_id` pending on each CPU c with `cfg_data[c]` set. The pending state stays until that CPU acknowledges it.
- R7: Private and software sources keep independent enable, priority, pending and active state per CPU. Activity on one CPU never changes what the other CPU is offered for the same ID.
- R8: A disabled source is never signalled or granted, whatever the state of its line.
- R9: End-of-interrupt clears the active state of the given ID for that CPU. A level source whose line is still high becomes pending again on the same edge.
- R10: `irq_o[c]` goes high one cycle after a candidate exists whose priority value is below both CPU c's mask and the smallest priority among CPU c's active interrupts. Acknowledge grants only under that same condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_op | input | 3 | Configuration operation code |
| cfg_cpu | input | 1 | CPU bank selected for private writes and mask writes |
| cfg_id | input | ID_W | Interrupt ID addressed |
| cfg_data | input | DW | Write data (DW = max(PRIO_W, 2)) |
| ppi_i | input | 2 x N_PPI | Private level lines, one group per CPU |
| spi_i | input | N_SPI | Shared level lines |
| ack_i | input | 2 | Acknowledge pulse per CPU |
| eoi_i | input | 2 | End-of-interrupt pulse per CPU |
| eoi_id_i | input | 2 x ID_W | ID released by each CPU |
| irq_o | output | 2 | Registered interrupt request per CPU |
| ack_id_o | output | 2 x ID_W | Registered ID returned by the last acknowledge |

## Verification
The bench builds the block with two software, two private and four shared sources and a 2-bit priority. That gives an 8-entry ID space whose spurious code is 15, and leaves only four priority levels. With so few levels, ties, mask cut-offs and blocking by the running priority all come up in short sequences. The small shared group still lets every ordering case be reached: a dual-target source taken by both CPUs at once, a release sent by the wrong CPU, and a level line still high at release. All of these are reached within a few hundred cycles.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int NCPU = 2;

  typedef enum logic [2:0] {
    OP_ENABLE = 3'd0,
    OP_PRIO   = 3'd1,
    OP_TARGET = 3'd2,
    OP_RAISE  = 3'd3,
    OP_MASK   = 3'd4
  } cfg_op_e;
endpackage

// File: rtl/irqd_select.sv
// Picks the candidate with the smallest priority value; ties keep the lower index.
module irqd_select #(
  parameter int N      = 8,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 4
) (
  input  logic [N-1:0]             cand,
  input  logic [N-1:0][PRIO_W-1:0] prio,
  output logic                     found,
  output logic [ID_W-1:0]          id,
  output logic [PRIO_W-1:0]        best
);
  always_comb begin
    found = 1'b0;
    id    = '0;
    best  = '1;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!found || prio[i] < best)) begin
        found = 1'b1;
        id    = ID_W'(i);
        best  = prio[i];
      end
    end
  end
endmodule

// File: rtl/irqd_bank.sv
// Per-CPU copy of software-raised and private source state.
module irqd_bank #(
  parameter int N_SGI  = 4,
  parameter int N_PPI  = 2,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 4,
  localparam int NL    = N_SGI + N_PPI
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en_we,
  input  logic                      pr_we,
  input  logic                      raise_we,
  input  logic [ID_W-1:0]           wr_idx,
  input  logic                      wr_bit,
  input  logic [PRIO_W-1:0]         wr_prio,
  input  logic [N_PPI-1:0]          ppi_line,
  input  logic [NL-1:0]             take,
  input  logic [NL-1:0]             eoi,
  output logic [NL-1:0]             cand,
  output logic [NL-1:0]             act,
  output logic [NL-1:0][PRIO_W-1:0] prio
);
  logic [NL-1:0]    en;
  logic [NL-1:0]    act_n;
  logic [N_SGI-1:0] sgi_pend;
  logic [N_SGI-1:0] raise_vec;
  logic [N_PPI-1:0] ppi_pend;

  always_comb begin
    act_n = (act | take) & ~eoi;
    for (int l = 0; l < N_SGI; l++)
      raise_vec[l] = raise_we && (wr_idx == ID_W'(l));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en       <= '0;
      prio     <= '0;
      act      <= '0;
      sgi_pend <= '0;
      ppi_pend <= '0;
    end else begin
      for (int l = 0; l < NL; l++) begin
        if (en_we && wr_idx == ID_W'(l)) en[l]   <= wr_bit;
        if (pr_we && wr_idx == ID_W'(l)) prio[l] <= wr_prio;
      end
      act      <= act_n;
      sgi_pend <= (sgi_pend & ~take[N_SGI-1:0]) | raise_vec;
      ppi_pend <= ppi_line & ~act_n[NL-1:N_SGI];
    end
  end

  assign cand = {ppi_pend, sgi_pend} & en & ~act;

  generate
    for (genvar l = 0; l < NL; l++) begin : g_chk
      p_take_active_r4: assert property (@(posedge clk) disable iff (rst)
        take[l] && !eoi[l] |=> act[l]);
      p_eoi_clears_r9: assert property (@(posedge clk) disable iff (rst)
        eoi[l] |=> !act[l]);
    end
  endgenerate
endmodule

// File: rtl/irq_dist2.sv
module irq_dist2
  import irqd_pkg::*;
#(
  parameter int N_SGI  = 4,
  parameter int N_PPI  = 2,
  parameter int N_SPI  = 6,
  parameter int PRIO_W = 3,
  localparam int NL    = N_SGI + N_PPI,
  localparam int NSRC  = NL + N_SPI,
  localparam int ID_W  = $clog2(NSRC + 1),
  localparam int DW    = (PRIO_W > NCPU) ? PRIO_W : NCPU,
  localparam int CW    = $clog2(NCPU)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            cfg_we,
  input  logic [2:0]                      cfg_op,
  input  logic [CW-1:0]                   cfg_cpu,
  input  logic [ID_W-1:0]                 cfg_id,
  input  logic [DW-1:0]                   cfg_data,
  input  logic [NCPU-1:0][N_PPI-1:0]      ppi_i,
  input  logic [N_SPI-1:0]                spi_i,
  input  logic [NCPU-1:0]                 ack_i,
  input  logic [NCPU-1:0]                 eoi_i,
  input  logic [NCPU-1:0][ID_W-1:0]       eoi_id_i,
  output logic [NCPU-1:0]                 irq_o,
  output logic [NCPU-1:0][ID_W-1:0]       ack_id_o
);
  localparam logic [ID_W-1:0] SPUR = '1;

  cfg_op_e op;
  logic    id_sgi, id_local, id_spi;
  logic [ID_W-1:0] spi_idx;

  assign op       = cfg_op_e'(cfg_op);
  assign id_sgi   = int'(cfg_id) < N_SGI;
  assign id_local = int'(cfg_id) < NL;
  assign id_spi   = !id_local && int'(cfg_id) < NSRC;
  assign spi_idx  = cfg_id - ID_W'(NL);

  // shared source state
  logic [N_SPI-1:0]             s_en, s_pend, s_act, s_act_n, s_own;
  logic [N_SPI-1:0][PRIO_W-1:0] s_prio;
  logic [N_SPI-1:0][NCPU-1:0]   s_tgt;
  logic [NCPU-1:0][N_SPI-1:0]   s_take, s_eoi, s_tcol, s_ocol;

  // per-CPU views
  logic [NCPU-1:0][NL-1:0]               l_cand, l_act, l_take, l_eoi;
  logic [NCPU-1:0][NL-1:0][PRIO_W-1:0]   l_prio;
  logic [NCPU-1:0][NSRC-1:0]             cand_all, act_all;
  logic [NCPU-1:0][NSRC-1:0][PRIO_W-1:0] prio_all;
  logic [NCPU-1:0]                       found, rfound, elig, grant;
  logic [NCPU-1:0][ID_W-1:0]             bid, rid;
  logic [NCPU-1:0][PRIO_W-1:0]           bpr, rpr, pmask;

  // only shared IDs can collide; CPU 0 wins a same-cycle tie
  assign grant[0] = ack_i[0] && elig[0];
  assign grant[1] = ack_i[1] && elig[1] &&
                    !(grant[0] && bid[0] == bid[1] && int'(bid[1]) >= NL);

  generate
    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
      irqd_bank #(
        .N_SGI(N_SGI), .N_PPI(N_PPI), .PRIO_W(PRIO_W), .ID_W(ID_W)
      ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .en_we    (cfg_we && op == OP_ENABLE && int'(cfg_cpu) == c && id_local),
        .pr_we    (cfg_we && op == OP_PRIO && int'(cfg_cpu) == c && id_local),
        .raise_we (cfg_we && op == OP_RAISE && cfg_data[c] && id_sgi),
        .wr_idx   (cfg_id),
        .wr_bit   (cfg_data[0]),
        .wr_prio  (cfg_data[PRIO_W-1:0]),
        .ppi_line (ppi_i[c]),
        .take     (l_take[c]),
        .eoi      (l_eoi[c]),
        .cand     (l_cand[c]),
        .act      (l_act[c]),
        .prio     (l_prio[c])
      );

      for (genvar l = 0; l < NL; l++) begin : g_loc
        assign l_take[c][l] = grant[c] && bid[c] == ID_W'(l);
        assign l_eoi[c][l]  = eoi_i[c] && eoi_id_i[c] == ID_W'(l);
      end

      for (genvar i = 0; i < N_SPI; i++) begin : g_shr
        assign s_take[c][i] = grant[c] && bid[c] == ID_W'(NL + i);
        assign s_eoi[c][i]  = eoi_i[c] && eoi_id_i[c] == ID_W'(NL + i) &&
                              s_act[i] && (s_own[i] == (c != 0));
        assign s_tcol[c][i] = s_tgt[i][c];
        assign s_ocol[c][i] = s_act[i] && (s_own[i] == (c != 0));
      end

      assign cand_all[c] = {s_pend & s_en & ~s_act & s_tcol[c], l_cand[c]};
      assign act_all[c]  = {s_ocol[c], l_act[c]};
      assign prio_all[c] = {s_prio, l_prio[c]};

      irqd_select #(.N(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_pick (
        .cand(cand_all[c]), .prio(prio_all[c]),
        .found(found[c]), .id(bid[c]), .best(bpr[c])
      );
      irqd_select #(.N(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_run (
        .cand(act_all[c]), .prio(prio_all[c]),
        .found(rfound[c]), .id(rid[c]), .best(rpr[c])
      );

      assign elig[c] = found[c] && bpr[c] < pmask[c] &&
                       (!rfound[c] || bpr[c] < rpr[c]);

      always_ff @(posedge clk) begin
        if (rst) begin
          irq_o[c]    <= 1'b0;
          ack_id_o[c] <= SPUR;
          pmask[c]    <= '1;
        end else begin
          irq_o[c] <= elig[c];
          if (ack_i[c]) ack_id_o[c] <= grant[c] ? bid[c] : SPUR;
          if (cfg_we && op == OP_MASK && int'(cfg_cpu) == c)
            pmask[c] <= cfg_data[PRIO_W-1:0];
        end
      end

      p_mask_gate_r10: assert property (@(posedge clk) disable iff (rst)
        irq_o[c] |-> $past(bpr[c] < pmask[c]));
      p_granted_enabled_r8: assert property (@(posedge clk) disable iff (rst)
        grant[c] && int'(bid[c]) >= NL |-> s_en[int'(bid[c]) - NL]);
    end
  endgenerate

  assign s_act_n = (s_act | s_take[0] | s_take[1]) & ~(s_eoi[0] | s_eoi[1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      s_en   <= '0;
      s_prio <= '0;
      s_tgt  <= '0;
      s_pend <= '0;
      s_act  <= '0;
      s_own  <= '0;
    end else begin
      for (int i = 0; i < N_SPI; i++) begin
        if (cfg_we && id_spi && int'(spi_idx) == i) begin
          case (op)
            OP_ENABLE: s_en[i]   <= cfg_data[0];
            OP_PRIO:   s_prio[i] <= cfg_data[PRIO_W-1:0];
            OP_TARGET: s_tgt[i]  <= cfg_data[NCPU-1:0];
            default: ;
          endcase
        end
        if (s_take[1][i])      s_own[i] <= 1'b1;
        else if (s_take[0][i]) s_own[i] <= 1'b0;
      end
      s_act  <= s_act_n;
      s_pend <= spi_i & ~s_act_n;
    end
  end

  p_single_taker_r5: assert property (@(posedge clk) disable iff (rst)
    grant[0] && grant[1] |-> (bid[0] != bid[1] || int'(bid[0]) < NL));
endmodule

// File: tb/irq_dist2_test.sv
module irq_dist2_test;
  import irqd_pkg::*;

  localparam int NS = 2, NP = 2, NSP = 4, PW = 2;
  localparam int NL = NS + NP, NSRC = NL + NSP, IW = 4, SPUR = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic                 cfg_we = 0;
  logic [2:0]           cfg_op = 0;
  logic [0:0]           cfg_cpu = 0;
  logic [IW-1:0]        cfg_id = 0;
  logic [1:0]           cfg_data = 0;
  logic [1:0][NP-1:0]   ppi = '0;
  logic [NSP-1:0]       spi = '0;
  logic [1:0]           ack = '0, eoi = '0;
  logic [1:0][IW-1:0]   eoi_id = '0;
  logic [1:0]           irq;
  logic [1:0][IW-1:0]   ack_id;

  irq_dist2 #(.N_SGI(NS), .N_PPI(NP), .N_SPI(NSP), .PRIO_W(PW)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_cpu(cfg_cpu),
    .cfg_id(cfg_id), .cfg_data(cfg_data), .ppi_i(ppi), .spi_i(spi),
    .ack_i(ack), .eoi_i(eoi), .eoi_id_i(eoi_id), .irq_o(irq), .ack_id_o(ack_id)
  );

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit l_en[2][NL], l_pend[2][NL], l_act[2][NL];
  int l_pr[2][NL];
  bit s_en[NSRC], s_pend[NSRC], s_act[NSRC];
  bit s_tgt[NSRC][2];
  int s_pr[NSRC], s_own[NSRC];
  int pm[2];
  bit m_irq[2];
  int m_ack[2];
  bit started = 0;

  task automatic pick(input int c, input bit use_act, output bit f, output int id, output int pr);
    f = 0; id = 0; pr = 0;
    for (int i = 0; i < NSRC; i++) begin
      bit cd;
      int p;
      if (i < NL) begin
        cd = use_act ? l_act[c][i] : (l_pend[c][i] && l_en[c][i] && !l_act[c][i]);
        p  = l_pr[c][i];
      end else begin
        cd = use_act ? (s_act[i] && s_own[i] == c)
                     : (s_pend[i] && s_en[i] && !s_act[i] && s_tgt[i][c]);
        p  = s_pr[i];
      end
      if (cd && (!f || p < pr)) begin f = 1; id = i; pr = p; end
    end
  endtask

  task automatic step();
    bit el[2], g[2];
    int bi[2];
    started = 1;
    if (rst) begin
      for (int c = 0; c < 2; c++) begin
        for (int i = 0; i < NL; i++) begin
          l_en[c][i] = 0; l_pend[c][i] = 0; l_act[c][i] = 0; l_pr[c][i] = 0;
        end
        pm[c] = 3; m_irq[c] = 0; m_ack[c] = SPUR;
      end
      for (int i = 0; i < NSRC; i++) begin
        s_en[i] = 0; s_pend[i] = 0; s_act[i] = 0; s_pr[i] = 0; s_own[i] = 0;
        s_tgt[i][0] = 0; s_tgt[i][1] = 0;
      end
      return;
    end
    for (int c = 0; c < 2; c++) begin
      bit f, rf;
      int id, pr, rid, rpr;
      pick(c, 0, f, id, pr);
      pick(c, 1, rf, rid, rpr);
      el[c] = f && pr < pm[c] && (!rf || pr < rpr);
      bi[c] = id;
    end
    g[0] = ack[0] && el[0];
    g[1] = ack[1] && el[1] && !(g[0] && bi[0] == bi[1] && bi[1] >= NL);
    for (int c = 0; c < 2; c++) begin
      m_irq[c] = el[c];
      if (ack[c]) m_ack[c] = g[c] ? bi[c] : SPUR;
    end
    if (cfg_we) begin
      int id = int'(cfg_id);
      int cp = int'(cfg_cpu);
      case (int'(cfg_op))
        0: if (id < NL) l_en[cp][id] = cfg_data[0]; else if (id < NSRC) s_en[id] = cfg_data[0];
        1: if (id < NL) l_pr[cp][id] = int'(cfg_data); else if (id < NSRC) s_pr[id] = int'(cfg_data);
        2: if (id >= NL && id < NSRC) begin s_tgt[id][0] = cfg_data[0]; s_tgt[id][1] = cfg_data[1]; end
        4: pm[cp] = int'(cfg_data);
        default: ;
      endcase
    end
    for (int c = 0; c < 2; c++)
      if (g[c]) begin
        if (bi[c] < NL) begin l_act[c][bi[c]] = 1; if (bi[c] < NS) l_pend[c][bi[c]] = 0; end
        else begin s_act[bi[c]] = 1; s_own[bi[c]] = c; end
      end
    if (cfg_we && int'(cfg_op) == 3 && int'(cfg_id) < NS)
      for (int c = 0; c < 2; c++) if (cfg_data[c]) l_pend[c][int'(cfg_id)] = 1;
    for (int c = 0; c < 2; c++)
      if (eoi[c]) begin
        int id = int'(eoi_id[c]);
        if (id < NL) l_act[c][id] = 0;
        else if (id < NSRC && s_act[id] && s_own[id] == c) s_act[id] = 0;
      end
    for (int c = 0; c < 2; c++)
      for (int i = NS; i < NL; i++) l_pend[c][i] = ppi[c][i-NS] && !l_act[c][i];
    for (int i = NL; i < NSRC; i++) s_pend[i] = spi[i-NL] && !s_act[i];
  endtask

  always @(posedge clk) step();

  always @(negedge clk)
    if (started)
      for (int c = 0; c < 2; c++) begin
        check(irq[c] == m_irq[c], "R10 model irq", int'(irq[c]), int'(m_irq[c]));
        check(int'(ack_id[c]) == m_ack[c], "R4 model ack id", int'(ack_id[c]), m_ack[c]);
      end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input int op, input int cpu, input int id, input int data);
    @(negedge clk);
    cfg_we = 1; cfg_op = 3'(op); cfg_cpu = 1'(cpu); cfg_id = IW'(id); cfg_data = 2'(data);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic do_ack(input logic [1:0] which, output int r0, output int r1);
    @(negedge clk);
    ack = which;
    @(negedge clk);
    ack = '0;
    r0 = int'(ack_id[0]);
    r1 = int'(ack_id[1]);
  endtask

  task automatic do_eoi(input logic [1:0] which, input int id0, input int id1);
    @(negedge clk);
    eoi = which; eoi_id[0] = IW'(id0); eoi_id[1] = IW'(id1);
    @(negedge clk);
    eoi = '0;
  endtask

  task automatic set_spi(input logic [NSP-1:0] v);
    @(negedge clk);
    spi = v;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int a0, a1;
    idle(3);
    check(irq == 2'b00, "R1 irq after reset", int'(irq), 0);
    check(int'(ack_id[0]) == SPUR && int'(ack_id[1]) == SPUR, "R1 ack id after reset",
          int'(ack_id[0]), SPUR);
    @(negedge clk) rst = 0;

    // shared source 4 on CPU 0
    cfg(0, 0, 4, 1); cfg(1, 0, 4, 2); cfg(2, 0, 4, 1);
    set_spi(4'b0001); idle(2);
    check(irq[0] == 1'b1, "R2 shared raised", int'(irq[0]), 1);
    check(irq[1] == 1'b0, "R2 not targeted cpu1", int'(irq[1]), 0);
    do_ack(2'b01, a0, a1); check(a0 == 4, "R4 ack id", a0, 4);
    idle(2); check(irq[0] == 1'b0, "R4 active not signalled", int'(irq[0]), 0);
    do_ack(2'b01, a0, a1); check(a0 == SPUR, "R4 spurious", a0, SPUR);
    do_eoi(2'b01, 4, 0); idle(1);
    check(irq[0] == 1'b1, "R9 level repends", int'(irq[0]), 1);
    do_ack(2'b01, a0, a1); check(a0 == 4, "R9 re-ack", a0, 4);
    set_spi(4'b0000); do_eoi(2'b01, 4, 0); idle(2);
    check(irq[0] == 1'b0, "R9 released", int'(irq[0]), 0);

    // priority and ties
    cfg(0, 0, 5, 1); cfg(1, 0, 5, 1); cfg(2, 0, 5, 1);
    cfg(0, 0, 6, 1); cfg(1, 0, 6, 1); cfg(2, 0, 6, 1);
    set_spi(4'b0111); idle(2);
    do_ack(2'b01, a0, a1); check(a0 == 5, "R3 tie lower id", a0, 5);
    do_ack(2'b01, a0, a1); check(a0 == SPUR, "R10 running priority blocks", a0, SPUR);
    set_spi(4'b0101); do_eoi(2'b01, 5, 0);
    do_ack(2'b01, a0, a1); check(a0 == 6, "R3 next priority", a0, 6);
    set_spi(4'b0001); do_eoi(2'b01, 6, 0);
    do_ack(2'b01, a0, a1); check(a0 == 4, "R3 lowest urgency last", a0, 4);
    set_spi(4'b0000); do_eoi(2'b01, 4, 0);

    // disabled source
    cfg(1, 0, 7, 0); cfg(2, 0, 7, 1);
    set_spi(4'b1000); idle(3);
    check(irq[0] == 1'b0, "R8 disabled quiet", int'(irq[0]), 0);
    do_ack(2'b01, a0, a1); check(a0 == SPUR, "R8 disabled not granted", a0, SPUR);
    cfg(0, 0, 7, 1); idle(1);
    check(irq[0] == 1'b1, "R8 enabled signals", int'(irq[0]), 1);
    do_ack(2'b01, a0, a1); check(a0 == 7, "R8 enabled granted", a0, 7);
    set_spi(4'b0000); do_eoi(2'b01, 7, 0);

    // priority mask
    cfg(4, 0, 0, 1);
    set_spi(4'b0001); idle(2);
    check(irq[0] == 1'b0, "R10 masked quiet", int'(irq[0]), 0);
    do_ack(2'b01, a0, a1); check(a0 == SPUR, "R10 masked spurious", a0, SPUR);
    cfg(4, 0, 0, 3);
    do_ack(2'b01, a0, a1); check(a0 == 4, "R10 unmasked", a0, 4);
    set_spi(4'b0000); do_eoi(2'b01, 4, 0);

    // dual-target shared source
    cfg(2, 0, 4, 3);
    set_spi(4'b0001); idle(2);
    check(irq == 2'b11, "R5 both signalled", int'(irq), 3);
    do_ack(2'b11, a0, a1);
    check(a0 == 4, "R5 cpu0 wins", a0, 4);
    check(a1 == SPUR, "R5 cpu1 loses", a1, SPUR);
    do_ack(2'b10, a0, a1); check(a1 == SPUR, "R5 not offered while active", a1, SPUR);
    do_eoi(2'b10, 0, 4);
    do_ack(2'b10, a0, a1); check(a1 == SPUR, "R5 foreign eoi ignored", a1, SPUR);
    do_eoi(2'b01, 4, 0);
    do_ack(2'b10, a0, a1); check(a1 == 4, "R5 offered after release", a1, 4);
    set_spi(4'b0000); do_eoi(2'b10, 0, 4);

    // software-raised
    cfg(0, 0, 1, 1); cfg(0, 1, 1, 1);
    cfg(3, 0, 1, 2);
    do_ack(2'b01, a0, a1); check(a0 == SPUR, "R6 untargeted cpu0", a0, SPUR);
    do_ack(2'b10, a0, a1); check(a1 == 1, "R6 targeted cpu1", a1, 1);
    do_eoi(2'b10, 0, 1);
    cfg(3, 0, 1, 3);
    do_ack(2'b11, a0, a1);
    check(a0 == 1, "R6 both cpu0", a0, 1);
    check(a1 == 1, "R7 banked cpu1", a1, 1);
    do_eoi(2'b11, 1, 1);
    idle(2); check(irq == 2'b00, "R6 cleared on ack", int'(irq), 0);

    // private banked sources
    cfg(0, 0, 2, 1);
    @(negedge clk) ppi = 4'b0101;
    idle(2);
    do_ack(2'b10, a0, a1); check(a1 == SPUR, "R7 disabled on cpu1", a1, SPUR);
    do_ack(2'b01, a0, a1); check(a0 == 2, "R7 granted on cpu0", a0, 2);
    cfg(0, 1, 2, 1);
    do_ack(2'b10, a0, a1); check(a1 == 2, "R7 independent cpu1", a1, 2);
    @(negedge clk) ppi = '0;
    do_eoi(2'b11, 2, 2);

    // reset mid-operation
    set_spi(4'b0001); idle(2);
    do_ack(2'b01, a0, a1); check(a0 == 4, "R1 pre-reset grant", a0, 4);
    @(negedge clk) rst = 1;
    idle(2);
    @(negedge clk) rst = 0;
    idle(2);
    check(irq == 2'b00, "R1 reset clears", int'(irq), 0);
    do_ack(2'b01, a0, a1); check(a0 == SPUR, "R1 nothing after reset", a0, SPUR);
    set_spi(4'b0000);
    idle(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule